// File: doc/BRIEF.md
# Spread-Spectrum Switching Clock Generator

This block makes the gate pulse train for the power switch of a boost converter. It runs from a fast, fixed reference clock. A phase accumulator adds an increment on every reference cycle. Each time the accumulator overflows, one switching period ends and the next begins. The increment is worked out from a 5-bit frequency code. The top bit of that code picks one of two octave ranges. The low four bits step linearly through sixteen points inside the chosen range.

A 2-bit spread code can turn on a triangular dither of the increment around the programmed centre. The dither spans 8 % peak to peak. The triangle moves one step per switching period, and one full up-and-down sweep takes 8, 32 or 128 periods. Code changes from the configuration register are picked up only at the boundary between two periods. A change therefore never cuts a period short.

Top module: `swclk_gen`

## Requirements
- R1: With the reference clock at 64 MHz and frequency code bit 4 = 0, the switching frequency is 800 kHz × (15 + k) / 15, where k is the value of code bits 3:0. This runs from 800 kHz at k = 0 to 1600 kHz at k = 15.
- R2: With frequency code bit 4 = 1, the switching frequency is half the R1 value for the same k. This runs from 400 kHz to 800 kHz.
- R3: While reset is held, gate_o is 1 and cycle_o is 0. Reset clears the captured codes, so the first period after reset runs at 800 kHz whatever codes sit on the inputs.
- R4: gate_o goes high at the start of each switching period and stays high for the first half of the period, within one reference cycle.
- R5: cycle_o is high for exactly one reference cycle. That cycle is the first cycle of each switching period.
- R6: Spread code 00 turns modulation off. Every period then has the same length, within one reference cycle.
- R7: Spread codes 01, 10 and 11 sweep the frequency in a triangle whose total span is 8 % of the centre. The centre is the R1/R2 frequency, so the swing is ±4 %. Averaged over one full sweep, the frequency equals the centre.
- R8: One sweep lasts N periods: N = 8 for spread code 01, N = 32 for 10 and N = 128 for 11. The triangle steps once per period. When a new spread code is taken up, the sweep restarts at its lowest frequency and rises for N/2 periods.
- R9: A change on freq_code or spread_code takes effect only at the next period boundary. The period in progress finishes at its old length.
- R10: For every legal code, each period lasts between 38 and 168 reference cycles, so no runt pulse can reach the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (64 MHz by default) |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_code | input | 5 | Bit 4 selects the range (0 high, 1 low); bits 3:0 select the step |
| spread_code | input | 2 | 00 off; 01, 10, 11 give a sweep of 8, 32 or 128 periods |
| gate_o | output | 1 | Switch gate drive, high in the first half of each period |
| cycle_o | output | 1 | One-cycle strobe marking the start of each period |

## Verification
The bench changes the frequency code partway through a period. A design that applied the change at once would turn out a truncated or stretched period instead of one at the old length. The bench holds a non-zero code through reset. A design that loaded it straight away would show a short first period instead of 80 cycles.

For each spread code the bench records a run of period lengths and checks several properties. The sweep must start at the slow end. The pattern must repeat after exactly N periods and must be reversed half a sweep later. The span must be near 8 %, and the average must land on the centre. A wrong sweep length, a sweep that does not restart, or an offset that is not centred would each fail one of these checks. Randomly chosen codes in both ranges catch step or range errors in the code-to-increment mapping.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

   typedef struct packed {
      logic       range_lo;
      logic [3:0] step;
   } fcode_t;

   typedef struct packed {
      fcode_t     f;
      logic [1:0] ss;
   } cfg_t;

   // Phase increment that yields hz at the given reference for an acc_w-bit accumulator
   function automatic longint unsigned hz_to_inc(longint unsigned hz,
                                                 longint unsigned ref_hz,
                                                 int acc_w);
      return (hz << acc_w) / ref_hz;
   endfunction

endpackage

// File: rtl/swclk_inc_map.sv
module swclk_inc_map #(
   parameter int               ACC_W    = 32,
   parameter logic [ACC_W-1:0] BASE_INC = '0,
   parameter logic [ACC_W-1:0] STEP_INC = '0
) (
   input  logic [4:0]       code_i,
   output logic [ACC_W-1:0] center_o
);
   import swclk_pkg::*;

   fcode_t           code;
   logic [ACC_W-1:0] hi_inc;

   always_comb begin
      code     = fcode_t'(code_i);
      hi_inc   = BASE_INC + STEP_INC * ACC_W'(code.step);
      center_o = code.range_lo ? (hi_inc >> 1) : hi_inc;
   end

endmodule

// File: rtl/swclk_sweep.sv
module swclk_sweep #(
   parameter int ACC_W     = 32,
   parameter int DEV_NUM   = 41,
   parameter int DEV_SHIFT = 9,
   parameter int LG1       = 3,
   parameter int LG2       = 5,
   parameter int LG3       = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [1:0]       ss_i,
   input  logic [1:0]       ss_nxt_i,
   input  logic [ACC_W-1:0] center_i,
   output logic [ACC_W-1:0] inc_o
);
   localparam int CNT_W  = LG3;
   localparam int SPAN_W = ACC_W + 8;
   localparam int PROD_W = SPAN_W + CNT_W + 1;

   function automatic int lg_of(logic [1:0] ss);
      case (ss)
         2'd1:    return LG1;
         2'd2:    return LG2;
         default: return LG3;
      endcase
   endfunction

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W:0]    n_len, half, tri_v, cnt_x;
   logic [CNT_W-1:0]  mask_nxt;
   logic [SPAN_W-1:0] span;
   logic [PROD_W-1:0] prod;
   logic              restart;
   int                lg;

   always_comb begin
      lg       = lg_of(ss_i);
      n_len    = (CNT_W+1)'(1) << lg;
      half     = n_len >> 1;
      cnt_x    = {1'b0, cnt_q};
      tri_v    = (cnt_x < half) ? cnt_x : (n_len - cnt_x);
      span     = (SPAN_W'(center_i) * SPAN_W'(DEV_NUM)) >> DEV_SHIFT;
      prod     = (PROD_W'(span) * PROD_W'(tri_v)) >> (lg - 1);
      mask_nxt = CNT_W'(((CNT_W+1)'(1) << lg_of(ss_nxt_i)) - 1'b1);
      restart  = (ss_nxt_i != ss_i);
      if (ss_i == 2'd0)
         inc_o = center_i;
      else
         inc_o = center_i - ACC_W'(span >> 1) + ACC_W'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step_i) begin
         if (restart || ss_nxt_i == 2'd0)
            cnt_q <= '0;
         else
            cnt_q <= (cnt_q + 1'b1) & mask_nxt;
      end
   end

   // R8: the triangle position stays inside the active sweep length
   assert_cnt_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_i != 2'd0) |-> (cnt_x < n_len));

   // R8: taking up a new spread code restarts the sweep at its low end
   assert_sweep_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && restart) |=> (cnt_q == '0));

endmodule

// File: rtl/swclk_phase_acc.sv
module swclk_phase_acc #(
   parameter int ACC_W      = 32,
   parameter int MIN_PERIOD = 38,
   parameter int MAX_PERIOD = 168
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] inc_i,
   output logic             wrap_o,
   output logic             gate_o,
   output logic             cycle_o
);
   localparam int PER_W = 16;

   logic [ACC_W-1:0] acc_q, acc_sum;
   logic             cyc_q;
   logic [PER_W-1:0] per_cnt;

   always_comb {wrap_o, acc_sum} = {1'b0, acc_q} + {1'b0, inc_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cyc_q <= 1'b0;
      end else begin
         acc_q <= acc_sum;
         cyc_q <= wrap_o;
      end
   end

   assign gate_o  = ~acc_q[ACC_W-1];
   assign cycle_o = cyc_q;

   // length-of-period tracker for the bound checks below
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                per_cnt <= '0;
      else if (wrap_o)           per_cnt <= '0;
      else if (~&per_cnt)        per_cnt <= per_cnt + 1'b1;
   end

   assert_period_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> (32'(per_cnt) + 1 >= MIN_PERIOD));

   assert_period_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
      32'(per_cnt) < MAX_PERIOD);

   assert_gate_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_o |-> gate_o);

   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_o |=> !cycle_o);

endmodule

// File: rtl/swclk_gen.sv
module swclk_gen #(
   parameter int REF_HZ    = 64_000_000,
   parameter int ACC_W     = 32,
   parameter int FMIN_HZ   = 800_000,
   parameter int STEPS     = 16,
   parameter int DEV_NUM   = 41,
   parameter int DEV_SHIFT = 9,
   parameter int SS_LG1    = 3,
   parameter int SS_LG2    = 5,
   parameter int SS_LG3    = 7,
   parameter bit SPREAD_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [4:0] freq_code,
   input  logic [1:0] spread_code,
   output logic       gate_o,
   output logic       cycle_o
);
   import swclk_pkg::*;

   localparam longint unsigned FULL     = 64'(1) << ACC_W;
   localparam longint unsigned BASE_L   = hz_to_inc(64'(FMIN_HZ), 64'(REF_HZ), ACC_W);
   localparam longint unsigned STEP_L   = BASE_L / 64'(STEPS - 1);
   localparam longint unsigned TOP_L    = BASE_L + STEP_L * 64'(STEPS - 1);
   localparam longint unsigned TOP_MAX  = TOP_L + ((TOP_L * 64'(DEV_NUM)) >> DEV_SHIFT) / 2 + 1;
   localparam longint unsigned LOW_L    = BASE_L >> 1;
   localparam longint unsigned LOW_MIN  = LOW_L - ((LOW_L * 64'(DEV_NUM)) >> DEV_SHIFT) / 2 - 1;
   localparam int              MIN_PER  = int'(FULL / TOP_MAX);
   localparam int              MAX_PER  = int'(FULL / LOW_MIN) + 2;
   localparam logic [ACC_W-1:0] BASE_INC = ACC_W'(BASE_L);
   localparam logic [ACC_W-1:0] STEP_INC = ACC_W'(STEP_L);

   initial begin
      assert (ACC_W >= 16 && ACC_W <= 48) else $error("swclk_gen: ACC_W out of range");
      assert (STEPS == 16) else $error("swclk_gen: step field is 4 bits");
      assert (SS_LG1 >= 1 && SS_LG1 < SS_LG2 && SS_LG2 < SS_LG3)
         else $error("swclk_gen: sweep lengths must rise");
      assert (DEV_NUM > 0 && DEV_NUM < 256 && DEV_SHIFT > SS_LG3)
         else $error("swclk_gen: deviation scale out of range");
      assert (2 * FMIN_HZ < REF_HZ / 4) else $error("swclk_gen: reference too slow");
   end

   cfg_t             cfg_q, cfg_in, cfg_nxt;
   logic [ACC_W-1:0] center, inc;
   logic             wrap;

   always_comb begin
      cfg_in  = cfg_t'({freq_code, spread_code});
      cfg_nxt = wrap ? cfg_in : cfg_q;
   end

   // codes are captured only when a period ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_nxt;
   end

   swclk_inc_map #(.ACC_W(ACC_W), .BASE_INC(BASE_INC), .STEP_INC(STEP_INC)) u_map (
      .code_i   (cfg_q.f),
      .center_o (center)
   );

   generate
      if (SPREAD_EN) begin : g_sweep
         swclk_sweep #(
            .ACC_W(ACC_W), .DEV_NUM(DEV_NUM), .DEV_SHIFT(DEV_SHIFT),
            .LG1(SS_LG1), .LG2(SS_LG2), .LG3(SS_LG3)
         ) u_sweep (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (wrap),
            .ss_i     (cfg_q.ss),
            .ss_nxt_i (cfg_nxt.ss),
            .center_i (center),
            .inc_o    (inc)
         );
      end else begin : g_flat
         assign inc = center;
      end
   endgenerate

   swclk_phase_acc #(.ACC_W(ACC_W), .MIN_PERIOD(MIN_PER), .MAX_PERIOD(MAX_PER)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc),
      .wrap_o  (wrap),
      .gate_o  (gate_o),
      .cycle_o (cycle_o)
   );

   // R9: captured configuration moves only in the first cycle of a period
   assert_cfg_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> cycle_o);

endmodule

// File: tb/swclk_gen_bench.sv
module swclk_gen_bench;
   localparam int CLK_NS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] freq_code = 5'b01111;
   logic [1:0] spread_code = 2'b00;
   logic       gate_o, cycle_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int p [256];

   always #(CLK_NS/2) clk = ~clk;

   swclk_gen u_swclk_gen (
      .clk(clk), .rst_n(rst_n), .freq_code(freq_code), .spread_code(spread_code),
      .gate_o(gate_o), .cycle_o(cycle_o)
   );

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   // reference cycles per period times n, from the R1/R2 formula
   function automatic int exp_cycles(logic [4:0] code, int n);
      real f;
      f = 800000.0 * (15.0 + real'(code[3:0])) / 15.0;
      if (code[4]) f = f / 2.0;
      return $rtoi(real'(n) * 64.0e6 / f + 0.5);
   endfunction

   task automatic wait_strobe();
      do @(negedge clk); while (!cycle_o);
   endtask

   // called at a strobe cycle; returns the length of the period that starts there
   task automatic period(output int len);
      len = 0;
      do begin @(negedge clk); len++; end while (!cycle_o);
   endtask

   task automatic settle(logic [4:0] fc, logic [1:0] sc);
      freq_code   = fc;
      spread_code = sc;
      wait_strobe();
   endtask

   task automatic freq_test(logic [4:0] fc);
      int tot, len, ex;
      settle(fc, 2'b00);
      tot = 0;
      for (int i = 0; i < 16; i++) begin period(len); tot += len; end
      ex = exp_cycles(fc, 16);
      check(iabs(tot - ex) <= 3, fc[4] ? "R2 low range frequency" : "R1 high range frequency",
            tot, ex);
   endtask

   initial begin
      int len, hi, mx, mn, tot, ex, n, half, dmax;
      logic [4:0] rc;
      void'($urandom(32'd20240611));

      // R3: reset state, with a non-zero code waiting on the input
      repeat (3) @(negedge clk);
      check(gate_o == 1'b1, "R3 gate high in reset", int'(gate_o), 1);
      check(cycle_o == 1'b0, "R3 strobe low in reset", int'(cycle_o), 0);
      rst_n = 1'b1;
      len = 0;
      do begin @(negedge clk); len++; end while (!cycle_o);
      check(len >= 80 && len <= 82, "R3 first period uses cleared code", len, 81);
      // R5: strobe lasts one cycle
      @(negedge clk);
      check(cycle_o == 1'b0, "R5 strobe width", int'(cycle_o), 0);
      wait_strobe();
      // R9: the code 01111 captured at the first boundary now gives 40 cycles
      period(len);
      check(iabs(len - 40) <= 1, "R9 captured code applied next period", len, 40);

      // directed range corners
      freq_test(5'b00000);
      freq_test(5'b01111);
      freq_test(5'b10000);
      freq_test(5'b11111);
      // random codes in both ranges
      for (int i = 0; i < 8; i++) begin
         rc = 5'($urandom());
         freq_test(rc);
      end

      // R4: gate high for the first half of the period
      settle(5'b00000, 2'b00);
      hi = 0; len = 0;
      do begin if (gate_o) hi++; @(negedge clk); len++; end while (!cycle_o);
      check(iabs(hi - 40) <= 1, "R4 gate high half at 800k", hi, 40);
      settle(5'b10000, 2'b00);
      hi = 0;
      do begin if (gate_o) hi++; @(negedge clk); end while (!cycle_o);
      check(iabs(hi - 80) <= 1, "R4 gate high half at 400k", hi, 80);

      // R9: change mid-period, the running period keeps its old length
      settle(5'b00000, 2'b00);
      repeat (10) @(negedge clk);
      freq_code = 5'b01111;
      len = 10;
      do begin @(negedge clk); len++; end while (!cycle_o);
      check(iabs(len - 80) <= 1, "R9 running period unaffected", len, 80);
      period(len);
      check(iabs(len - 40) <= 1, "R9 new code next period", len, 40);

      // R6: no modulation with spread off
      settle(5'b00000, 2'b00);
      mx = 0; mn = 1000;
      for (int i = 0; i < 16; i++) begin
         period(len);
         if (len > mx) mx = len;
         if (len < mn) mn = len;
      end
      check(mx - mn <= 1, "R6 constant period with spread off", mx - mn, 0);

      // R7/R8: each spread code, centre 800 kHz (80 cycles)
      for (int s = 1; s <= 3; s++) begin
         n    = (s == 1) ? 8 : (s == 2) ? 32 : 128;
         half = n / 2;
         settle(5'b00000, 2'(s));
         for (int i = 0; i < 2 * n; i++) period(p[i]);
         tot = 0; mx = 0; mn = 1000;
         for (int i = 0; i < n; i++) begin
            tot += p[i];
            if (p[i] > mx) mx = p[i];
            if (p[i] < mn) mn = p[i];
         end
         ex = 80 * n;
         check(iabs(tot - ex) <= ex / 200 + 3, "R7 sweep average at centre", tot, ex);
         check(mx - mn >= 5 && mx - mn <= 9, "R7 sweep span near 8 percent", mx - mn, 7);
         check(p[0] - p[half] >= 5, "R8 sweep starts at low frequency", p[0] - p[half], 6);
         dmax = 0;
         for (int i = 0; i < n; i++)
            if (iabs(p[i] - p[i + n]) > dmax) dmax = iabs(p[i] - p[i + n]);
         check(dmax <= 1, "R8 sweep repeats after N periods", dmax, 0);
         dmax = 0;
         for (int i = 0; i < n; i++)
            if (iabs(p[i] - p[i + half]) > dmax) dmax = iabs(p[i] - p[i + half]);
         check(dmax >= 5, "R8 sweep reversed after N/2 periods", dmax, 6);
      end

      // R10: fastest and slowest settings stay inside the period bounds
      settle(5'b01111, 2'b11);
      mn = 1000;
      for (int i = 0; i < 128; i++) begin period(len); if (len < mn) mn = len; end
      check(mn >= 38, "R10 shortest period bound", mn, 38);
      settle(5'b10000, 2'b11);
      mx = 0;
      for (int i = 0; i < 128; i++) begin period(len); if (len > mx) mx = len; end
      check(mx <= 168, "R10 longest period bound", mx, 168);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule